// File: doc/BRIEF.md
# Framing Bit Error Injector

This block sits in a T1 transmit path, after the framer. It takes the serial bit stream from the framer, one bit per strobe, and inverts chosen framing bits on purpose so that a far-end receiver can be tested. The framer marks each terminal-framing bit and each framing-pattern bit with its own flag. A mode input chooses which of the two flags marks a qualifying bit: the terminal-framing flag in superframe mode, or the framing-pattern flag in extended superframe mode. Every other bit passes through unchanged, with the same latency.

There are two ways to inject errors, and both count only qualifying bits. The first is a level-driven periodic mode. While it is enabled, one qualifying bit in every 128 is inverted. The second is an edge-driven burst. It inverts the next three qualifying bits, which is enough to make the far end lose frame alignment. A running count of inverted bits is provided so that the effect can be checked.

Top module: `fbit_corruptor`

## Requirements
- R1: A strobed bit that does not qualify appears on `bit_out` one clock after its strobe, unchanged. `out_vld` is high in that cycle. When `bit_en` is low, `out_vld` is low in the next cycle.
- R2: When `esf_mode`=0, only bits with `ft_mark`=1 qualify. When `esf_mode`=1, only bits with `fps_mark`=1 qualify. The other flag has no effect on the output.
- R3: While `cont_en` stays high, the 128th qualifying bit after it was raised is inverted, and so is every 128th qualifying bit after that. No other qualifying bit is inverted by this mode.
- R4: Clearing `cont_en` stops periodic inversion at once and restarts the 128-bit count. After `cont_en` is raised again, the first inversion falls on the 128th qualifying bit.
- R5: A rising edge of `burst_req`, sampled on `clk`, inverts the next three qualifying bits that are strobed in later cycles.
- R6: A rising edge of `burst_req` while a burst still has bits left to invert is ignored. Holding `burst_req` high does not start any further bursts.
- R7: A bit hit by both the burst and the periodic mode is inverted once. `inj_count` then rises by one.
- R8: `inj_count` rises by exactly one for each inverted bit, in the cycle that bit appears on `bit_out`, and at no other time.
- R9: After reset, `bit_out`=0, `out_vld`=0 and `inj_count`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit-domain clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_en | input | 1 | Strobe: `bit_in` carries a bit in this cycle |
| bit_in | input | 1 | Serial transmit data from the framer |
| ft_mark | input | 1 | Current bit is a terminal-framing bit |
| fps_mark | input | 1 | Current bit is a framing-pattern bit |
| esf_mode | input | 1 | 0 selects superframe mode, 1 selects extended superframe mode |
| cont_en | input | 1 | Level enable for periodic one-in-128 corruption |
| burst_req | input | 1 | A rising edge starts a three-bit burst |
| bit_out | output | 1 | Output data, one cycle after the strobe |
| out_vld | output | 1 | `bit_out` holds a new bit |
| inj_count | output | CNT_W | Running count of inverted bits |

## Verification
Directed runs drive long trains of qualifying bits mixed with non-qualifying ones. These separate the exact 128-bit phase of the periodic mode and its restart on re-enable from an off-by-one count. A burst is issued in superframe mode over bits that carry only the framing-pattern flag. This shows whether the mode select really picks the flag. Further cases aim a second edge into a running burst, and line the burst up with the 127th count so that both modes hit the same bit. These catch retriggering and double counting. A long seeded random phase varies the strobe density, both flags, the mode and both controls together, against a reference model in the bench.

// File: rtl/fbit_corruptor.sv
module fbit_corruptor #(
  parameter int PERIOD    = 128,
  parameter int BURST_LEN = 3,
  parameter int CNT_W     = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_en,
  input  logic             bit_in,
  input  logic             ft_mark,
  input  logic             fps_mark,
  input  logic             esf_mode,
  input  logic             cont_en,
  input  logic             burst_req,
  output logic             bit_out,
  output logic             out_vld,
  output logic [CNT_W-1:0] inj_count
);
  localparam int PC_W = $clog2(PERIOD);
  localparam int BL_W = $clog2(BURST_LEN + 1);

  logic [PC_W-1:0] per_cnt;
  logic [BL_W-1:0] burst_left;
  logic            burst_q;

  wire qual   = bit_en & (esf_mode ? fps_mark : ft_mark);
  wire rise   = burst_req & ~burst_q;
  wire b_hit  = qual & (burst_left != '0);
  wire p_hit  = qual & cont_en & (per_cnt == PC_W'(PERIOD - 1));
  wire flip   = b_hit | p_hit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      per_cnt    <= '0;
      burst_left <= '0;
      burst_q    <= 1'b0;
      bit_out    <= 1'b0;
      out_vld    <= 1'b0;
      inj_count  <= '0;
    end else begin
      burst_q <= burst_req;
      out_vld <= bit_en;
      if (bit_en) bit_out <= bit_in ^ flip;
      if (flip) inj_count <= inj_count + 1'b1;

      if (!cont_en)  per_cnt <= '0;
      else if (qual) per_cnt <= per_cnt + 1'b1;

      if (rise && burst_left == '0) burst_left <= BL_W'(BURST_LEN);
      else if (b_hit)               burst_left <= burst_left - 1'b1;
    end
  end

  a_r1_pass_through: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_en && !(esf_mode ? fps_mark : ft_mark)) |=> (out_vld && bit_out == $past(bit_in)));

  a_r1_idle_no_valid: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_en |=> !out_vld);

  a_r4_quiet_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_en && !cont_en && burst_left == '0) |=> bit_out == $past(bit_in));

  a_r5_burst_inverts: assert property (@(posedge clk) disable iff (!rst_n)
    (qual && burst_left != '0) |=> bit_out != $past(bit_in));

  a_r8_count_only_on_output: assert property (@(posedge clk) disable iff (!rst_n)
    (inj_count != $past(inj_count)) |-> out_vld);

  a_r7_count_step_one: assert property (@(posedge clk) disable iff (!rst_n)
    out_vld |-> (inj_count - $past(inj_count)) <= CNT_W'(1));
endmodule

// File: tb/fbit_corruptor_tb.sv
module fbit_corruptor_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bit_en = 0, bit_in = 0, ft_mark = 0, fps_mark = 0, esf_mode = 0;
  logic cont_en = 0, burst_req = 0;
  logic bit_out, out_vld;
  logic [15:0] inj_count;

  int total = 0, bad = 0;
  int m_pc = 0, m_bl = 0, m_cnt = 0;
  bit m_prev = 0;

  always #2 clk = ~clk;

  fbit_corruptor u_dut (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .bit_in(bit_in),
    .ft_mark(ft_mark), .fps_mark(fps_mark), .esf_mode(esf_mode),
    .cont_en(cont_en), .burst_req(burst_req),
    .bit_out(bit_out), .out_vld(out_vld), .inj_count(inj_count));

  function automatic bit is_qual(bit en, bit ft, bit fps, bit esf);
    return en && (esf ? fps : ft);
  endfunction

  task automatic chk(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(string tag, bit en, bit b, bit ft, bit fps, bit esf, bit cen, bit brq);
    bit q, flip, exp_bit;
    @(negedge clk);
    bit_en = en; bit_in = b; ft_mark = ft; fps_mark = fps;
    esf_mode = esf; cont_en = cen; burst_req = brq;
    q = is_qual(en, ft, fps, esf);
    flip = (q && m_bl != 0) || (q && cen && m_pc == 127);
    exp_bit = b ^ flip;
    if (!cen) m_pc = 0; else if (q) m_pc = (m_pc + 1) % 128;
    if (brq && !m_prev && m_bl == 0) m_bl = 3;
    else if (q && m_bl != 0) m_bl--;
    m_prev = brq;
    if (flip) m_cnt++;
    @(posedge clk); #1;
    chk({tag, " R1 valid"}, out_vld, en);
    if (en) chk(tag, bit_out, exp_bit);
    if (en) chk({tag, " R8 count"}, inj_count, m_cnt & 16'hFFFF);
  endtask

  task automatic qbit(string tag, bit esf, bit cen, bit brq);
    cyc(tag, 1, 1'($urandom), !esf, esf, esf, cen, brq);
  endtask

  initial begin
    #400000;
    bad++; total++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    #1;
    chk("R9 bit_out", bit_out, 0);
    chk("R9 out_vld", out_vld, 0);
    chk("R9 inj_count", inj_count, 0);
    @(negedge clk); rst_n = 1;

    for (int i = 0; i < 40; i++)
      cyc("R1", 1'($urandom), 1'($urandom), 0, 0, 1'($urandom), 0, 0);

    cyc("R5 edge", 0, 0, 0, 0, 0, 0, 1);
    for (int i = 0; i < 6; i++) cyc("R2 ignore fps in SF", 1, 1'($urandom), 0, 1, 0, 0, 1);
    for (int i = 0; i < 5; i++) cyc("R5", 1, 1'($urandom), 1, 0, 0, 0, 1);
    chk("R6 level held no retrigger", inj_count, 3);
    cyc("R5 low", 0, 0, 0, 0, 1, 0, 0);
    cyc("R5 edge esf", 0, 0, 0, 0, 1, 0, 1);
    for (int i = 0; i < 4; i++) cyc("R2 ignore ft in ESF", 1, 1'($urandom), 1, 0, 1, 0, 1);
    for (int i = 0; i < 5; i++) cyc("R5 esf", 1, 1'($urandom), 0, 1, 1, 0, 0);
    chk("R5 total", inj_count, 6);

    cyc("R6 edge", 0, 0, 0, 0, 0, 0, 1);
    qbit("R6", 0, 0, 1);
    cyc("R6 drop", 0, 0, 0, 0, 0, 0, 0);
    cyc("R6 reedge", 0, 0, 0, 0, 0, 0, 1);
    for (int i = 0; i < 5; i++) qbit("R6", 0, 0, 1);
    chk("R6 retrigger ignored", inj_count, 9);
    cyc("R6 low", 0, 0, 0, 0, 0, 0, 0);

    for (int i = 0; i < 300; i++) begin
      qbit("R3", 0, 1, 0);
      if (i % 3 == 0) cyc("R3 gap", 1, 1'($urandom), 0, 1, 0, 1, 0);
    end
    chk("R3 two periodic", inj_count, 11);

    for (int i = 0; i < 50; i++) qbit("R4", 1, 1, 0);
    cyc("R4 off", 0, 0, 0, 0, 1, 0, 0);
    for (int i = 0; i < 130; i++) qbit("R4", 1, 1, 0);
    chk("R4 restart", inj_count, 12);

    cyc("R7 off", 0, 0, 0, 0, 0, 0, 0);
    for (int i = 0; i < 126; i++) qbit("R7 pre", 0, 1, 0);
    cyc("R7 edge", 0, 0, 0, 0, 0, 1, 1);
    for (int i = 0; i < 4; i++) qbit("R7", 0, 1, 1);
    chk("R7 coincide once", inj_count, 15);
    cyc("R7 low", 0, 0, 0, 0, 0, 0, 0);

    for (int i = 0; i < 4000; i++) begin
      bit e = ($urandom % 4) != 0;
      bit c = (i / 700) % 2 == 0;
      bit br = ($urandom % 40) < 3;
      cyc("RND", e, 1'($urandom), ($urandom % 3) == 0, ($urandom % 3) == 0,
          (i / 1300) % 2 == 1, c, br);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule